// File: doc/BRIEF.md
# Pulse-Skipping Divide-by-Sixty Prescaler

This block turns a slow square wave, such as a 60 Hz timing reference sampled into the system clock domain, into one tick per sixty input periods. It is not a binary counter with a compare. It models two cascaded ripple stages built from toggle elements. Each element inverts when its trigger signal falls. The first stage divides by ten and the second stage divides by six. In each stage, a control element gates one chain element so that it skips input pulses, which gives a ratio that is not a power of two.

All ripple activity is evaluated inside one system clock domain. A falling input edge is detected from a registered copy of the input. The toggle cascade is then worked out in ripple order within that one clock. Each element compares its trigger before and after the earlier elements update. A seed port loads any state into the first stage. The extra gating lets the stage recover from every start-up state, including the one that would otherwise freeze it.

Top module: `pulse_skip_div60`

## Requirements
- R1: A synchronous reset clears all stage elements and the edge detector. After reset `out10`, `out60`, `tap_ten` and `tap_six` read 0.
- R2: The first element of the ten stage (`tap_ten[0]`) toggles on every falling edge of `sq_in`. A rising edge or a steady input changes no state.
- R3: The second element (`tap_ten[1]`) toggles only when its trigger, first element AND NOT control, falls. While the control element (`tap_ten[3]`) is high, pulses from the first element are blocked.
- R4: The control element toggles when the OR of (third element AND NOT control) and (first element AND control) falls. It sets when the third element falls and clears on the next fall of the first element, including from the seeded state with the third element and the control element both high.
- R5: From reset, `tap_ten` read as the number {control, third, second, first} equals the count of input falling edges modulo 10. `out10` is the third element (`tap_ten[2]`). It first falls on the 8th input falling edge and then falls every 10.
- R6: The six stage follows the same scheme with its first element fed by `out10`. Its second element is triggered by first AND NOT control, and its control element by (second AND NOT control) OR (first AND control). `tap_six` read as {control, second, first} equals the count of `out10` falls modulo 6.
- R7: `out60` is the six stage's second element (`tap_six[1]`). From reset it first falls on the 38th input falling edge and then every 60. The six stage changes state only in a cycle where `out10` falls.
- R8: A pulse on `seed_en` loads `seed_state` into `tap_ten` with the same bit order and leaves the six stage unchanged. From any of the 16 seeds, `out10` falls at a steady spacing of 10 input edges within 20 input periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sq_in | input | 1 | Sampled input square wave |
| seed_en | input | 1 | Load `seed_state` into the ten stage |
| seed_state | input | 4 | Seed value {control, third, second, first} |
| out10 | output | 1 | Input divided by ten |
| out60 | output | 1 | Input divided by sixty |
| tap_ten | output | 4 | Ten stage state {control, third, second, first} |
| tap_six | output | 3 | Six stage state {control, second, first} |

## Verification
The embedded assertions check the local rules on every cycle. They cover the first element toggling on each input fall and staying still otherwise, and the control element blocking the second element. They also cover the control element clearing on a fall of the first element, and the six stage moving only on a fall of `out10`. The ratios themselves are shown only by the bench scenarios. These are the modulo-10 and modulo-6 state sequences, the exact positions of the first output falls, the 10 and 60 edge spacings, and recovery from all 16 seeded start states.

// File: rtl/pulse_skip_div60.sv
module pulse_skip_div60 (
  input  logic       clk,
  input  logic       rst,
  input  logic       sq_in,
  input  logic       seed_en,
  input  logic [3:0] seed_state,
  output logic       out10,
  output logic       out60,
  output logic [3:0] tap_ten,
  output logic [2:0] tap_six
);

  logic a_prev;
  logic tb, tc, td, te;
  logic sb, sc, sd;

  logic in_fall;
  assign in_fall = a_prev & ~sq_in;

  // ten stage, ripple order: first, second, third, control
  logic nb, nc, nd, ne;
  logic tc_trig_old, tc_trig_new, te_trig_old, te_trig_new;
  assign nb          = tb ^ in_fall;
  assign tc_trig_old = tb & ~te;
  assign tc_trig_new = nb & ~te;
  assign nc          = tc ^ (tc_trig_old & ~tc_trig_new);
  assign nd          = td ^ (tc & ~nc);
  assign te_trig_old = (td & ~te) | (tb & te);
  assign te_trig_new = (nd & ~te) | (nb & te);
  assign ne          = te ^ (te_trig_old & ~te_trig_new);

  // six stage, fed by falling edges of the ten stage output
  logic ten_fall;
  logic mb, mc, md;
  logic sc_trig_old, sc_trig_new, sd_trig_old, sd_trig_new;
  assign ten_fall    = td & ~nd;
  assign mb          = sb ^ ten_fall;
  assign sc_trig_old = sb & ~sd;
  assign sc_trig_new = mb & ~sd;
  assign mc          = sc ^ (sc_trig_old & ~sc_trig_new);
  assign sd_trig_old = (sc & ~sd) | (sb & sd);
  assign sd_trig_new = (mc & ~sd) | (mb & sd);
  assign md          = sd ^ (sd_trig_old & ~sd_trig_new);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev <= 1'b0;
      {te, td, tc, tb} <= 4'b0;
      {sd, sc, sb} <= 3'b0;
    end else begin
      a_prev <= sq_in;
      if (seed_en) begin
        {te, td, tc, tb} <= seed_state;
      end else begin
        {te, td, tc, tb} <= {ne, nd, nc, nb};
        {sd, sc, sb} <= {md, mc, mb};
      end
    end
  end

  assign out10   = td;
  assign out60   = sc;
  assign tap_ten = {te, td, tc, tb};
  assign tap_six = {sd, sc, sb};

  // R2: first element toggles on each input fall, and nothing moves without one
  a_r2_first_toggles: assert property (@(posedge clk) disable iff (rst)
    (in_fall && !seed_en) |=> (tap_ten[0] != $past(tap_ten[0])));
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!in_fall && !seed_en) |=> ($stable(tap_ten) && $stable(tap_six)));

  // R3: control high blocks the second element
  a_r3_control_blocks: assert property (@(posedge clk) disable iff (rst)
    (te && !seed_en) |=> $stable(tap_ten[1]));

  // R4: control clears on a fall of the first element
  a_r4_control_clears: assert property (@(posedge clk) disable iff (rst)
    (te && tb && in_fall && !seed_en) |=> !tap_ten[3]);

  // R7: six stage moves only when the ten stage output falls
  a_r7_six_on_ten_fall: assert property (@(posedge clk) disable iff (rst)
    !($past(out10) && !out10) |-> $stable(tap_six));

  // R8: seed loads the ten stage as given
  a_r8_seed_loads: assert property (@(posedge clk) disable iff (rst)
    seed_en |=> (tap_ten == $past(seed_state)));

endmodule

// File: tb/sim_pulse_skip_div60.sv
module sim_pulse_skip_div60;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sq_in = 1'b0;
  logic seed_en = 1'b0;
  logic [3:0] seed_state = 4'd0;
  logic out10, out60;
  logic [3:0] tap_ten;
  logic [2:0] tap_six;

  int n_chk = 0;
  int n_bad = 0;
  int n_fall = 0;
  logic last10 = 1'b0;
  logic last60 = 1'b0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  pulse_skip_div60 u0 (
    .clk(clk), .rst(rst), .sq_in(sq_in), .seed_en(seed_en),
    .seed_state(seed_state), .out10(out10), .out60(out60),
    .tap_ten(tap_ten), .tap_six(tap_six)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, n_fall);
    end
  endtask

  task automatic step();
    sq_in = 1'b1;
    repeat (3) @(negedge clk);
    sq_in = 1'b0;
    repeat (3) @(negedge clk);
    n_fall++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int first10, first60, prev10, prev60, cnt10;
    first10 = -1; first60 = -1; prev10 = -1; prev60 = -1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 tap_ten", int'(tap_ten), 0);
    check("R1 tap_six", int'(tap_six), 0);
    check("R1 outputs", int'({out60, out10}), 0);

    // R2 rising edge alone changes nothing
    sq_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 rise ignored", int'(tap_ten), 0);
    sq_in = 1'b0;
    repeat (3) @(negedge clk);
    n_fall = 1;
    check("R2 first toggle", int'(tap_ten), 1);
    last10 = out10; last60 = out60;

    for (int k = 2; k <= 130; k++) begin
      step();
      check("R5 ten state mod 10 (R3 R4)", int'(tap_ten), n_fall % 10);
      check("R6 six state mod 6", int'(tap_six), ((n_fall + 2) / 10) % 6);
      check("R5 out10 level", int'(out10), int'((n_fall % 10) >= 4 && (n_fall % 10) <= 7));
      check("R7 out60 level", int'(out60), int'(((n_fall + 2) / 10) % 6 >= 2 && ((n_fall + 2) / 10) % 6 <= 3));
      if (last10 && !out10) begin
        if (first10 < 0) first10 = n_fall;
        else check("R5 out10 spacing", n_fall - prev10, 10);
        prev10 = n_fall;
      end
      if (last60 && !out60) begin
        if (first60 < 0) first60 = n_fall;
        else check("R7 out60 spacing", n_fall - prev60, 60);
        prev60 = n_fall;
      end
      last10 = out10; last60 = out60;
    end
    check("R5 first out10 fall", first10, 8);
    check("R7 first out60 fall", first60, 38);

    // R4 lock-up seed: third and control both high
    seed_state = 4'b1100; seed_en = 1'b1;
    @(negedge clk);
    seed_en = 1'b0;
    check("R8 seed load", int'(tap_ten), 12);
    step();
    check("R4 lockup step1", int'(tap_ten), 13);
    step();
    check("R4 control cleared", int'(tap_ten), 4);

    // R8 sweep over all seeds
    for (int s = 0; s < 16; s++) begin
      logic [2:0] six_before;
      six_before = tap_six;
      seed_state = 4'(s); seed_en = 1'b1;
      @(negedge clk);
      seed_en = 1'b0;
      check("R8 seed load", int'(tap_ten), s);
      check("R8 six kept", int'(tap_six), int'(six_before));
      n_fall = 0; prev10 = -1; cnt10 = 0;
      last10 = out10;
      for (int k = 1; k <= 50; k++) begin
        step();
        if (last10 && !out10 && n_fall > 20) begin
          if (prev10 >= 0) check("R8 steady spacing", n_fall - prev10, 10);
          prev10 = n_fall;
          cnt10++;
        end
        last10 = out10;
      end
      check("R8 falls after settle", int'(cnt10 >= 2), 1);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule